// File: doc/BRIEF.md
# I2C Indexed Block-Transfer Register Target

This block is an I2C target that holds a small file of byte-wide registers. A host reaches it with indexed block transfers. A write transaction carries three things after the address byte: a starting register index, a byte count, and then that many data bytes, which land in consecutive registers. A read transaction first sets the index with a short write phase. A repeated start with the read address follows, and the target then returns the stored byte count ahead of the register contents. The index advances by one after every data byte, whether it was written or read.

SCL and SDA each pass through a synchroniser and a glitch filter before any start, stop or bit is decoded. The target drives SDA only as an open-drain pull-down enable, and it changes that enable only while SCL is low. The whole register file is visible to the surrounding chip as a flat vector. Reset values and a per-bit read-only mask are parameters.

Top module: `i2c_idx_target`

## Requirements
- R1: The target acknowledges the address byte only when it is 0xD4 (write) or 0xD5 (read). Any other address is not acknowledged, the rest of that transaction is ignored, and no register changes.
- R2: In a write, the target acknowledges the index byte, the count byte and each data byte it accepts. Accepted data byte k (counting from 0) is stored in register index+k.
- R3: Data bytes beyond the count received in the same write are not acknowledged and not stored. With a count of 0, the first data byte is already refused.
- R4: After a repeated start with 0xD5, the target first sends the count byte of the most recent write that had its count acknowledged. It then sends registers from the current index. It keeps sending while the host acknowledges, and stops driving after a host NACK.
- R5: The index advances after every stored or sent data byte. Indices at or above NUM_REGS read as 0xFF and ignore writes.
- R6: Read-only bits keep their value on a write. With the default mask, all of register 7 and bits 7:4 of register 6 are read-only.
- R7: A register changes only when a whole data byte has been received and acknowledged. A stop or start in the middle of a byte drops that byte and keeps bytes that were already committed.
- R8: After reset, registers hold REG_INIT (register 7 = 0x5A, all others 0x00 by default), the stored count is NUM_REGS, and SDA is released.
- R9: The SDA drive enable changes only while the filtered SCL is low.
- R10: A start or stop is an SDA edge while SCL is high. A start at any point begins a new address phase. SCL pulses shorter than FILT_LEN clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line, that is, the wired-AND of all drivers |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register file contents; register i sits at bits i*8+7 down to i*8 |

## Verification
The assertions assume the host behaves like a legal I2C controller. It keeps SDA steady while SCL is high, except for a deliberate start or stop. It holds each SCL level far longer than the filter and synchroniser delay. It never tries a start or stop while the target is pulling SDA low. The bench host holds each quarter bit period for 16 clocks. It moves SDA only during the low phase, except at starts and stops. The one exception is an intentional one-clock SCL glitch, kept shorter than the filter length. Aborted transfers always end on a bit boundary with SCL low, so the stop or repeated start that follows is well formed.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

    localparam logic [7:0] ADDR_WR = 8'hD4;
    localparam logic [7:0] ADDR_RD = 8'hD5;
    localparam int         IDX_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_RELOAD,
        ST_WAIT
    } xfer_state_e;

    typedef enum logic [1:0] {
        RB_ADDR,
        RB_INDEX,
        RB_COUNT,
        RB_DATA
    } byte_role_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return (b == ADDR_WR) || (b == ADDR_RD);
    endfunction

    function automatic logic [7:0] masked_merge(input logic [7:0] old_v,
                                                input logic [7:0] new_v,
                                                input logic [7:0] keep);
        return (old_v & keep) | (new_v & ~keep);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic clean_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
                clean_q <= 1'b1;
            end else if (~|hist_q) begin
                clean_q <= 1'b0;
            end
        end
    end

    assign clean_o = clean_q;
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] clean;
    logic             scl_q;
    logic             sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[l]),
            .clean_o(clean[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= clean[1];
            sda_q <= clean[0];
        end
    end

    assign scl_f    = clean[1];
    assign sda_f    = clean[0];
    assign ev_start = scl_q & scl_f & sda_q & ~sda_f;
    assign ev_stop  = scl_q & scl_f & ~sda_q & sda_f;
    assign scl_rise = ~scl_q & scl_f;
    assign scl_fall = scl_q & ~scl_f;

    AST_SDA_EDGE_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |-> $past(scl_f)); // R10
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_blk_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] REG_INIT = '0,
    parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr_i,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= REG_INIT[g*8 +: 8];
            end else if (wr_i.en && (wr_i.idx == IDX_W'(g))) begin
                regs_q[g] <= masked_merge(regs_q[g], wr_i.data, RO_MASK[g*8 +: 8]);
            end
        end
        assign regs_o[g*8 +: 8] = regs_q[g];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $stable(regs_o & RO_MASK)); // R6

    AST_OUT_OF_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && (int'(wr_i.idx) >= NUM_REGS)) |=> $stable(regs_o)); // R5
endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
    import i2c_blk_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output wr_req_t          wr_o,
    output logic             sda_oe
);
    localparam logic [7:0] CNT_RST = 8'(NUM_REGS);

    xfer_state_e      state_q;
    byte_role_e       role_q;
    logic [3:0]       bit_q;
    logic [7:0]       sh_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       cnt_q;
    logic [7:0]       left_q;
    logic             tx_data_q;
    logic             oe_q;
    wr_req_t          wr_q;
    logic             want_ack;

    always_comb begin
        unique case (role_q)
            RB_ADDR: want_ack = addr_hit(sh_q);
            RB_DATA: want_ack = (left_q != 8'd0);
            default: want_ack = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            role_q    <= RB_ADDR;
            bit_q     <= '0;
            sh_q      <= '0;
            idx_q     <= '0;
            cnt_q     <= CNT_RST;
            left_q    <= '0;
            tx_data_q <= 1'b0;
            oe_q      <= 1'b0;
            wr_q      <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev_stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else if (ev_start) begin
                state_q <= ST_RX;
                role_q  <= RB_ADDR;
                bit_q   <= '0;
                oe_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_RX: begin
                        if (scl_rise && (bit_q < 4'd8)) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            bit_q <= bit_q + 4'd1;
                        end else if (scl_fall && (bit_q == 4'd8)) begin
                            if (want_ack) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_ACK;
                            end else begin
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            bit_q   <= '0;
                            state_q <= ST_RX;
                            unique case (role_q)
                                RB_ADDR: begin
                                    if (sh_q[0]) begin
                                        sh_q      <= cnt_q;
                                        oe_q      <= ~cnt_q[7];
                                        tx_data_q <= 1'b0;
                                        state_q   <= ST_TX;
                                    end else begin
                                        role_q <= RB_INDEX;
                                    end
                                end
                                RB_INDEX: begin
                                    idx_q  <= sh_q;
                                    role_q <= RB_COUNT;
                                end
                                RB_COUNT: begin
                                    cnt_q  <= sh_q;
                                    left_q <= sh_q;
                                    role_q <= RB_DATA;
                                end
                                default: begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.idx  <= idx_q;
                                    wr_q.data <= sh_q;
                                    idx_q     <= idx_q + IDX_W'(1);
                                    left_q    <= left_q - 8'd1;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_q == 4'd7) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_HACK;
                                if (tx_data_q) begin
                                    idx_q <= idx_q + IDX_W'(1);
                                end
                            end else begin
                                sh_q  <= {sh_q[6:0], 1'b0};
                                oe_q  <= ~sh_q[6];
                                bit_q <= bit_q + 4'd1;
                            end
                        end
                    end
                    ST_HACK: begin
                        if (scl_rise) begin
                            state_q <= sda_f ? ST_WAIT : ST_RELOAD;
                        end
                    end
                    ST_RELOAD: begin
                        if (scl_fall) begin
                            sh_q      <= rd_data;
                            oe_q      <= ~rd_data[7];
                            bit_q     <= '0;
                            tx_data_q <= 1'b1;
                            state_q   <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx = idx_q;
    assign wr_o   = wr_q;
    assign sda_oe = oe_q;

    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bit_q <= 4'd8); // R2

    AST_WRITE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> ($past(left_q) != 8'd0)); // R3

    AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> $past(oe_q)); // R7

    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> !scl_f); // R9

    AST_START_REOPENS_ADDR: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (state_q == ST_RX && role_q == RB_ADDR && bit_q == 4'd0)); // R10
endmodule

// File: rtl/i2c_idx_target.sv
module i2c_idx_target
    import i2c_blk_pkg::*;
#(
    parameter int                    NUM_REGS    = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter int                    FILT_LEN    = 3,
    parameter logic [NUM_REGS*8-1:0] REG_INIT    = 64'h5A00_0000_0000_0000,
    parameter logic [NUM_REGS*8-1:0] RO_MASK     = 64'hFFF0_0000_0000_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic             scl_f;
    logic             sda_f;
    logic             ev_start;
    logic             ev_stop;
    logic             scl_rise;
    logic             scl_fall;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] rd_idx;
    wr_req_t          wr_req;

    i2c_bus_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    i2c_xfer_engine #(
        .NUM_REGS(NUM_REGS)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_o    (wr_req),
        .sda_oe  (sda_oe)
    );

    i2c_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .REG_INIT(REG_INIT),
        .RO_MASK (RO_MASK)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_req),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .regs_o (regs_o)
    );
endmodule

// File: tb/test_i2c_idx_target.sv
module test_i2c_idx_target;
    localparam int NR = 8;
    localparam int Q  = 16;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_h = 1'b1;
    logic          sda_h = 1'b1;
    logic          sda_bus;
    logic          sda_oe;
    logic [NR*8-1:0] regs_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] mdl [NR];
    logic [7:0] romask [NR];
    logic [7:0] cnt_mdl;
    logic [7:0] tx_buf [16];

    always #5 clk = ~clk;

    assign sda_bus = sda_h & ~sda_oe;

    i2c_idx_target i_i2c_idx_target (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_h),
        .sda_i (sda_bus),
        .sda_oe(sda_oe),
        .regs_o(regs_o)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected byte", g, 8'h00);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(g == e.val, e.tag, g, e.val);
                end
            end
        end
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; qw();
        sda_h = 1'b0; qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; qw();
        scl_h = 1'b1; qw();
        sda_h = 1'b0; qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qw();
        scl_h = 1'b1; qw();
        sda_h = 1'b1; qw();
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; qw();
        scl_h = 1'b1; qw(); qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; qw();
        scl_h = 1'b1; qw();
        b = sda_bus; qw();
        scl_h = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic host_ack);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            d[i] = b;
        end
        got_q.push_back(d);
        put_bit(~host_ack);
    endtask

    task automatic mdl_write(input logic [7:0] idx, input logic [7:0] d);
        if (int'(idx) < NR) mdl[idx] = (mdl[idx] & romask[idx]) | (d & ~romask[idx]);
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NR; i++) check(regs_o[i*8 +: 8] == mdl[i], tag, regs_o[i*8 +: 8], mdl[i]);
    endtask

    task automatic glitch_scl();
        @(negedge clk) scl_h = 1'b1;
        @(negedge clk) scl_h = 1'b0;
        qw();
    endtask

    task automatic wr_xfer(input logic [7:0] idx, input logic [7:0] cnt, input int n, input bit glitch);
        logic a;
        bus_start();
        send_byte(8'hD4, a); check(a == 1'b1, "R1 write address ack", {7'd0, a}, 8'h01);
        send_byte(idx, a);   check(a == 1'b1, "R2 index ack", {7'd0, a}, 8'h01);
        send_byte(cnt, a);   check(a == 1'b1, "R2 count ack", {7'd0, a}, 8'h01);
        cnt_mdl = cnt;
        if (glitch) glitch_scl();
        for (int i = 0; i < n; i++) begin
            bit exp_ack;
            exp_ack = (i < int'(cnt));
            send_byte(tx_buf[i], a);
            check(a == exp_ack, "R3 data ack vs count", {7'd0, a}, {7'd0, exp_ack});
            if (!exp_ack) break;
            mdl_write(idx + 8'(i), tx_buf[i]);
        end
        bus_stop();
    endtask

    task automatic rd_xfer(input logic [7:0] idx, input int n);
        logic a;
        bus_start();
        send_byte(8'hD4, a); check(a == 1'b1, "R1 write address ack", {7'd0, a}, 8'h01);
        send_byte(idx, a);   check(a == 1'b1, "R4 index ack", {7'd0, a}, 8'h01);
        bus_rstart();
        send_byte(8'hD5, a); check(a == 1'b1, "R1 read address ack", {7'd0, a}, 8'h01);
        exp_q.push_back('{cnt_mdl, "R4 count byte first"});
        recv_byte(n > 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] p;
            p = idx + 8'(i);
            exp_q.push_back('{(int'(p) < NR) ? mdl[p] : 8'hFF, "R5 read data / auto-increment"});
            recv_byte(i < n - 1);
        end
        bus_stop();
        check(sda_oe == 1'b0, "R4 released after NACK", {7'd0, sda_oe}, 8'h00);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < NR; i++) begin
            mdl[i] = 8'h00;
            romask[i] = 8'h00;
        end
        mdl[7] = 8'h5A;
        romask[7] = 8'hFF;
        romask[6] = 8'hF0;
        cnt_mdl = 8'(NR);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R8 reset state
        check(sda_oe == 1'b0, "R8 sda released at reset", {7'd0, sda_oe}, 8'h00);
        chk_regs("R8 reset values");
        rd_xfer(8'h00, 2);

        // R2 basic block write then read back
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        wr_xfer(8'h01, 8'd3, 3, 1'b0);
        chk_regs("R2 consecutive write");
        rd_xfer(8'h00, 5);

        // R5/R6 write over read-only bits and past the end
        tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hAA; tx_buf[3] = 8'hBB;
        wr_xfer(8'h06, 8'd4, 4, 1'b0);
        chk_regs("R6 read-only bits kept");
        rd_xfer(8'h05, 6);

        // R3 count limit and count zero
        tx_buf[0] = 8'h44; tx_buf[1] = 8'h55; tx_buf[2] = 8'h66;
        wr_xfer(8'h00, 8'd2, 3, 1'b0);
        chk_regs("R3 bytes past count refused");
        tx_buf[0] = 8'h77;
        wr_xfer(8'h03, 8'd0, 1, 1'b0);
        chk_regs("R3 zero count refuses data");

        // R1 foreign address
        bus_start();
        send_byte(8'hA0, a); check(a == 1'b0, "R1 foreign address NACK", {7'd0, a}, 8'h00);
        send_byte(8'h00, a); check(a == 1'b0, "R1 rest ignored", {7'd0, a}, 8'h00);
        bus_stop();
        chk_regs("R1 no change after foreign address");

        // R7 stop inside a byte
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h04, a);
        send_byte(8'h03, a);
        cnt_mdl = 8'h03;
        send_byte(8'h99, a); check(a == 1'b1, "R7 first byte ack", {7'd0, a}, 8'h01);
        mdl_write(8'h04, 8'h99);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        chk_regs("R7 stop drops partial byte");

        // R7/R10 repeated start inside a byte becomes a read
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h04, a);
        send_byte(8'h02, a);
        cnt_mdl = 8'h02;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_rstart();
        send_byte(8'hD5, a); check(a == 1'b1, "R10 start mid-byte reopens address", {7'd0, a}, 8'h01);
        exp_q.push_back('{cnt_mdl, "R10 count after restart"});
        recv_byte(1'b1);
        exp_q.push_back('{mdl[4], "R7 committed byte survives abort"});
        recv_byte(1'b0);
        bus_stop();
        chk_regs("R7 no change from aborted byte");

        // R10 short SCL glitch ignored
        tx_buf[0] = 8'hC3;
        wr_xfer(8'h02, 8'd1, 1, 1'b1);
        chk_regs("R10 glitch filtered");
        rd_xfer(8'h02, 1);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected bytes seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule